// File: doc/BRIEF.md
# Cascadable Serial Configuration Bitstream Reader

This block is the read side of a serial configuration store. It holds a fixed bit array, set by a parameter, and shifts it out one bit per data-clock rising edge to load an SRAM-based FPGA. Several copies can be chained. Each copy's cascade-select output drives the chip-select input of the next copy, and all copies share the data clock and the data line. The result is one concatenated stream.

The role of each copy is set while its reset input is at the reset level. A copy whose chip select is low then becomes the master. The master makes the data clock from a divider on the system clock. A copy whose chip select is high becomes a follower. A follower takes the data clock from outside, passes it through a two-flop synchronizer and an edge detector, and turns each rising edge into a one-cycle advance strobe. The whole design runs on one system clock.

The three-state data pin is modelled as a data value plus an enable. The data value is meaningful only while the enable is high. The polarity of the reset/output-enable input is a parameter.

Top module: `cfgStreamReader`

## Requirements
- R1: Each advance moves the bit address up by one. The data output presents stored bit k, where INIT bit 0 is presented first after reset and bits follow in ascending index order.
- R2: An advance happens only while the input is at its enable level, chip select is low, serial enable is high and the stream is not finished. In any other case, data-clock edges leave the address unchanged.
- R3: While the reset/output-enable input is at its reset level, the address clears to 0 and the finished flag clears. After release, bit 0 is presented.
- R4: With RST_HIGH = 0 (the default), a low level is reset and a high level is enable. With RST_HIGH = 1, the two levels are swapped.
- R5: The master's dclkOut is a square wave. Each high phase and each low phase lasts HALF_DIV system clocks, so rising edges are 2*HALF_DIV clocks apart. The master advances once per rising edge. dclkOut is held low during reset, while counting is disabled, and after the stream is finished.
- R6: A copy whose chip select is low while reset is applied becomes master. A copy whose chip select is high during reset becomes a follower, and a follower's dclkOut stays low.
- R7: cascN (active low) goes low on the DEPTH-th advance and stays low until the next reset.
- R8: dataEn is high only when the input is not at its reset level, chip select is low, serial enable is high and the stream is not finished. In a chain, at most one copy drives at a time.
- R9: In follower mode, a rising edge on dclkIn changes the data output on the third system-clock edge after it and causes exactly one advance.
- R10: While serial enable is low, the address is held, dataEn is low and the master clock stays low. When serial enable returns high, the same bit is presented again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstOe | input | 1 | Combined reset / output enable; polarity set by RST_HIGH |
| csN | input | 1 | Chip select, active low; also sampled during reset to pick the role |
| serEn | input | 1 | Serial enable; must be high for readout |
| dclkIn | input | 1 | External data clock used in follower mode |
| dclkOut | output | 1 | Data clock generated in master mode, low otherwise |
| dataOut | output | 1 | Currently presented stream bit |
| dataEn | output | 1 | Drive enable of the three-state data line |
| cascN | output | 1 | Cascade select, low once the whole array has been sent |

## Verification
Master-mode results are tied to the divider. A rise of dclkOut and the step of the address to the next bit happen on the same system edge, so the bench records the data line on every falling system edge and compares, at each rise, the value recorded one edge earlier. Follower results are due on the third system edge after dclkIn rises. The bench drives dclkIn on a falling edge, checks that the old bit is still present two falling edges later and that the new bit is present one edge after that, and waits four edges per clock phase before its regular samples. Gating and reset effects are read one or more falling edges after the input change, once every register on the path has updated.

// File: rtl/cfgrd_pkg.sv
package cfgrd_pkg;

  // Strobes sent by the control half to the datapath half.
  typedef struct packed {
    logic clear;    // reset level present: zero address and finished flag
    logic advance;  // step to the next stored bit
  } rdStrobe_t;

endpackage

// File: rtl/cfgrd_ctrl.sv
module cfgrd_ctrl
  import cfgrd_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter bit RST_HIGH = 1'b0
) (
  input  logic      clk,
  input  logic      rstOe,
  input  logic      csN,
  input  logic      serEn,
  input  logic      dclkIn,
  input  logic      done,
  output rdStrobe_t strb,
  output logic      dclkOut,
  output logic      dataEn
);

  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);

  logic             rstAct;
  logic             isMaster;
  logic [DIV_W-1:0] divCnt;
  logic             dclkReg;
  logic [1:0]       syncQ;
  logic             syncPrev;
  logic             gate;
  logic             masterRun;
  logic             tick;
  logic             extRise;

  assign rstAct    = RST_HIGH ? rstOe : ~rstOe;
  assign gate      = serEn & ~csN;
  assign masterRun = isMaster & gate & ~done;
  assign tick      = (divCnt == DIV_LAST);
  assign extRise   = syncQ[1] & ~syncPrev;

  always_ff @(posedge clk) begin
    if (rstAct) begin
      isMaster <= ~csN;
      divCnt   <= '0;
      dclkReg  <= 1'b0;
      syncQ    <= '0;
      syncPrev <= 1'b0;
    end else begin
      syncQ    <= {syncQ[0], dclkIn};
      syncPrev <= syncQ[1];
      if (masterRun) begin
        if (tick) begin
          divCnt  <= '0;
          dclkReg <= ~dclkReg;
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end else begin
        divCnt  <= '0;
        dclkReg <= 1'b0;
      end
    end
  end

  always_comb begin
    strb.clear   = rstAct;
    strb.advance = ~rstAct & gate & ~done &
                   (isMaster ? (tick & ~dclkReg) : extRise);
  end

  assign dclkOut = dclkReg;
  assign dataEn  = ~rstAct & gate & ~done;

  AST_CLK_LOW_IDLE: assert property (@(posedge clk) disable iff (rstAct)
    !(isMaster && serEn && !csN && !done) |=> !dclkOut);                 // R5
  AST_FOLLOWER_QUIET: assert property (@(posedge clk) disable iff (rstAct)
    !isMaster |-> !dclkOut);                                             // R6
  AST_ADVANCE_ON_RISE: assert property (@(posedge clk) disable iff (rstAct)
    (strb.advance && isMaster) |=> dclkOut);                             // R1

endmodule

// File: rtl/cfgrd_datapath.sv
module cfgrd_datapath
  import cfgrd_pkg::*;
#(
  parameter int               DEPTH = 16,
  parameter logic [DEPTH-1:0] INIT  = '0
) (
  input  logic      clk,
  input  rdStrobe_t strb,
  output logic      dataBit,
  output logic      done
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] addr;

  always_ff @(posedge clk) begin
    if (strb.clear) begin
      addr <= '0;
      done <= 1'b0;
    end else if (strb.advance) begin
      if (addr == LAST) begin
        done <= 1'b1;
      end else begin
        addr <= addr + 1'b1;
      end
    end
  end

  assign dataBit = INIT[addr];

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (strb.clear)
    done |=> done);                                                      // R7
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (strb.clear)
    !strb.advance |=> $stable(addr));                                    // R2
  AST_NO_ADVANCE_DONE: assert property (@(posedge clk) disable iff (strb.clear)
    done |-> !strb.advance);                                             // R2
  AST_DONE_AT_LAST: assert property (@(posedge clk) disable iff (strb.clear)
    done |-> (addr == LAST));                                            // R7

endmodule

// File: rtl/cfgStreamReader.sv
module cfgStreamReader
  import cfgrd_pkg::*;
#(
  parameter int               DEPTH    = 16,
  parameter int               HALF_DIV = 2,
  parameter bit               RST_HIGH = 1'b0,
  parameter logic [DEPTH-1:0] INIT     = '0
) (
  input  logic clk,
  input  logic rstOe,
  input  logic csN,
  input  logic serEn,
  input  logic dclkIn,
  output logic dclkOut,
  output logic dataOut,
  output logic dataEn,
  output logic cascN
);

  rdStrobe_t strb;
  logic      done;

  cfgrd_ctrl #(
    .HALF_DIV(HALF_DIV),
    .RST_HIGH(RST_HIGH)
  ) uCtrl (
    .clk    (clk),
    .rstOe  (rstOe),
    .csN    (csN),
    .serEn  (serEn),
    .dclkIn (dclkIn),
    .done   (done),
    .strb   (strb),
    .dclkOut(dclkOut),
    .dataEn (dataEn)
  );

  cfgrd_datapath #(
    .DEPTH(DEPTH),
    .INIT (INIT)
  ) uData (
    .clk    (clk),
    .strb   (strb),
    .dataBit(dataOut),
    .done   (done)
  );

  assign cascN = ~done;

endmodule

// File: tb/sim_cfgStreamReader.sv
`timescale 1ns/1ps
module sim_cfgStreamReader;

  localparam int          D  = 16;
  localparam int          HD = 2;
  localparam logic [15:0] A  = 16'h5AC3;
  localparam logic [15:0] B  = 16'h9E21;
  localparam logic [15:0] C  = 16'h7B14;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  int nChecks = 0;
  int nFails  = 0;

  logic rstA, cs0, serA, ext;
  logic rst2, cs2, ser2;
  logic extZero;
  logic dclk0, d0, e0, casc0;
  logic dclk1, d1, e1, casc1;
  logic dclk2, d2, e2, casc2;

  assign extZero = 1'b0;

  cfgStreamReader #(.DEPTH(D), .HALF_DIV(HD), .RST_HIGH(1'b0), .INIT(A)) u0 (
    .clk(clk), .rstOe(rstA), .csN(cs0), .serEn(serA), .dclkIn(ext),
    .dclkOut(dclk0), .dataOut(d0), .dataEn(e0), .cascN(casc0));

  cfgStreamReader #(.DEPTH(D), .HALF_DIV(HD), .RST_HIGH(1'b0), .INIT(B)) u1 (
    .clk(clk), .rstOe(rstA), .csN(casc0), .serEn(serA), .dclkIn(ext),
    .dclkOut(dclk1), .dataOut(d1), .dataEn(e1), .cascN(casc1));

  cfgStreamReader #(.DEPTH(D), .HALF_DIV(HD), .RST_HIGH(1'b1), .INIT(C)) u2 (
    .clk(clk), .rstOe(rst2), .csN(cs2), .serEn(ser2), .dclkIn(extZero),
    .dclkOut(dclk2), .dataOut(d2), .dataEn(e2), .cascN(casc2));

  task automatic check(input bit ok, input string req, input int got, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic logic merged();
    return e0 ? d0 : d1;
  endfunction

  task automatic pulseExt();
    ext = 1'b1;
    repeat (4) @(negedge clk);
    ext = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic resetChain();
    @(negedge clk);
    rstA = 1'b0;
    cs0  = 1'b1;
    repeat (4) @(negedge clk);
    check(!e0 && !e1, "R8 no drive in reset", int'(e0) + int'(e1), 0);
    check(casc0 && casc1, "R3 cascade released in reset", int'(casc0), 1);
    rstA = 1'b1;
    @(negedge clk);
    cs0 = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic resetMaster();
    @(negedge clk);
    rst2 = 1'b1;
    cs2  = 1'b0;
    ser2 = 1'b1;
    repeat (4) @(negedge clk);
    check(!dclk2 && !e2, "R4 high level is reset for inverted copy", int'(dclk2), 0);
    rst2 = 1'b0;
  endtask

  initial begin
    #1000000;
    nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    int rises, lastRise, pauseRises;
    logic prevD, prevClk;
    rstA = 1'b0; cs0 = 1'b1; serA = 1'b1; ext = 1'b0;
    rst2 = 1'b1; cs2 = 1'b0; ser2 = 1'b1;
    repeat (4) @(negedge clk);
    check(!e0 && !e1 && casc0 && casc1, "R3 reset state", int'(e0), 0);
    check(!dclk2, "R5 master clock low in reset", int'(dclk2), 0);

    // partial stream, with follower latency check on the first edge
    resetChain();
    check(merged() == A[0], "R3 bit 0 after reset", int'(merged()), int'(A[0]));
    ext = 1'b1;
    repeat (2) @(negedge clk);
    check(d0 == A[0], "R9 old bit two edges after rise", int'(d0), int'(A[0]));
    @(negedge clk);
    check(d0 == A[1], "R9 new bit on third edge", int'(d0), int'(A[1]));
    @(negedge clk);
    ext = 1'b0;
    repeat (4) @(negedge clk);
    for (int k = 1; k < 7; k++) begin
      check(merged() == A[k], "R1 partial stream", int'(merged()), int'(A[k]));
      pulseExt();
    end

    // reset in the middle of a stream
    resetChain();
    check(merged() == A[0] && e0, "R3 restart after mid-stream reset", int'(merged()), int'(A[0]));

    // full chained stream
    for (int k = 0; k < 2 * D; k++) begin
      logic expBit;
      expBit = (k < D) ? A[k] : B[k - D];
      check(merged() == expBit, "R1 chained stream", int'(merged()), int'(expBit));
      check(e0 ^ e1, "R8 exactly one driver", int'(e0) + int'(e1), 1);
      check(casc0 == (k < D), "R7 cascade on last advance", int'(casc0), int'(k < D));
      check(!dclk0 && !dclk1, "R6 follower clock low", int'(dclk0), 0);
      if (k == 5) begin
        serA = 1'b0;
        pulseExt();
        pulseExt();
        check(!e0 && !e1, "R10 no drive with serial enable low", int'(e0), 0);
        serA = 1'b1;
        @(negedge clk);
        check(merged() == A[5], "R10 address held", int'(merged()), int'(A[5]));
      end
      if (k == 9) begin
        cs0 = 1'b1;
        pulseExt();
        check(!e0 && !e1, "R2 no drive with chip select high", int'(e0), 0);
        cs0 = 1'b0;
        @(negedge clk);
        check(merged() == A[9], "R2 address held", int'(merged()), int'(A[9]));
      end
      pulseExt();
    end
    check(!e0 && !e1 && !casc1, "R7 chain finished", int'(e0) + int'(e1), 0);
    pulseExt();
    check(!e0 && !e1 && !casc0 && !casc1, "R2 edges ignored after finish", int'(casc1), 0);

    // master run, inverted polarity
    resetMaster();
    rises = 0; lastRise = 0;
    prevD = d2; prevClk = dclk2;
    for (int n = 0; n < 200; n++) begin
      @(negedge clk);
      if (dclk2 && !prevClk) begin
        if (rises < D)
          check(prevD == C[rises], "R1 master stream", int'(prevD), int'(C[rises]));
        if (rises > 0)
          check(n - lastRise == 2 * HD, "R5 clock period", n - lastRise, 2 * HD);
        rises++;
        lastRise = n;
      end
      prevD = d2;
      prevClk = dclk2;
    end
    check(rises == D, "R5 one rise per bit", rises, D);
    check(!dclk2 && !casc2 && !e2, "R7 master finished and clock low", int'(dclk2), 0);

    // master run with a serial-enable pause
    resetMaster();
    rises = 0; pauseRises = 0;
    prevClk = dclk2;
    for (int n = 0; n < 200; n++) begin
      @(negedge clk);
      if (n == 20) ser2 = 1'b0;
      if (n == 39) begin
        check(!dclk2 && !e2, "R10 master clock held low", int'(dclk2), 0);
        ser2 = 1'b1;
      end
      if (dclk2 && !prevClk) begin
        rises++;
        if (n > 21 && n < 40) pauseRises++;
      end
      prevClk = dclk2;
    end
    check(pauseRises == 0, "R10 no rises while paused", pauseRises, 0);
    check(rises == D, "R10 full count after pause", rises, D);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule